// File: doc/BRIEF.md
# Square Collision Acceleration Unit

This unit takes a pair of axis-aligned square bodies, called A and B, and returns the push that their contact gives to A. It yields three signed 16-bit values: a linear acceleration on x, a linear acceleration on y and an angular acceleration. Each body is given by its centre coordinates and its side length. Each body also carries an elasticity coefficient. Body A additionally supplies a precomputed reciprocal of its mass, so the unit never divides.

The force on each axis is the overlap area, times the centre separation on that axis, times the sum of the two elasticities. The acceleration is that force times A's reciprocal mass. The angular term takes the larger of the two axis results and reverses its sign. Every result is clipped to the 16-bit signed range. The unit is fully pipelined and accepts a new pair on every clock. A valid flag travels with each pair, and its results appear exactly four cycles later. Summing the results over many pairs is left to the logic around the unit.

Top module: `sq_collide_accel`

## Requirements
- R1: Per axis, the half-extent sum is (a_side + b_side)/2 and the overlap is max(0, half-extent sum − |A centre − B centre|). Centres are unsigned 8.8 fixed point (bits 15:8 integer, bits 7:0 fraction) and sides are unsigned integers. If the overlap on either axis is zero, including the case where the squares exactly touch, all three outputs are 0.
- R2: The magnitude of acc_x is ovx·ovy·|dx|·(a_elas + b_elas)·a_rmass, truncated to an integer. Here ovx and ovy are the two overlaps, |dx| is the x centre separation (both in real units from 8.8), and elasticities and reciprocal mass are unsigned 4.4 (bits 7:4 integer, bits 3:0 fraction).
- R3: The magnitude of acc_y is ovx·ovy·|dy|·(a_elas + b_elas)·a_rmass, truncated to an integer, using the same encodings as R2.
- R4: On each axis, if A's centre coordinate is smaller than B's, that axis acceleration is negative or zero; otherwise it is positive or zero.
- R5: acc_ang is the negation of whichever of acc_x and acc_y has the larger magnitude before clipping, with x chosen on a tie. The negation is applied before clipping.
- R6: Each output is clipped to −32768..32767. A magnitude of 32768 or more becomes −32768 when the value is negative and 32767 when it is positive.
- R7: out_valid rises on the fourth rising clock edge after the edge that samples in_valid high, and it carries that pair's results. One pair is accepted on every cycle, and a cycle with in_valid low gives a cycle with out_valid low.
- R8: A synchronous active-high rst clears out_valid and all three outputs to 0 on the next edge. It also discards every pair still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pair on the inputs is valid |
| a_x | input | 16 | Centre x of A, unsigned 8.8 |
| a_y | input | 16 | Centre y of A, unsigned 8.8 |
| a_side | input | 5 | Side length of A, unsigned integer |
| a_elas | input | 8 | Elasticity of A, unsigned 4.4 |
| a_rmass | input | 8 | Reciprocal mass of A, unsigned 4.4 |
| b_x | input | 16 | Centre x of B, unsigned 8.8 |
| b_y | input | 16 | Centre y of B, unsigned 8.8 |
| b_side | input | 5 | Side length of B, unsigned integer |
| b_elas | input | 8 | Elasticity of B, unsigned 4.4 |
| out_valid | output | 1 | Results belong to a valid pair |
| acc_x | output | 16 | Signed x acceleration on A |
| acc_y | output | 16 | Signed y acceleration on A |
| acc_ang | output | 16 | Signed angular acceleration on A |

## Verification
The three results for a pair are all due together, on the fourth rising edge after the edge that samples the pair. The bench drives each pair on a falling edge. It then compares the outputs at the falling edge four cycles later against a reference model that works in 64-bit integers. Pairs are sent back to back, with bubbles between some of them. Each compare at a falling edge is matched to the pair driven four slots earlier, so a design one cycle early or late shows up as wrong values or wrong valid flags. For a mid-stream reset, the bench checks at the first falling edge after the reset edge, and then checks that no stale pair emerges during the following four cycles.

// File: rtl/sq_coll_pkg.sv
package sq_coll_pkg;
  localparam int POS_W_D     = 16;
  localparam int POS_FRAC_D  = 8;
  localparam int SIDE_W_D    = 5;
  localparam int COEF_W_D    = 8;
  localparam int COEF_FRAC_D = 4;
  localparam int ACC_W_D     = 16;
  localparam int N_AXES      = 2;

  typedef enum int {AXIS_X = 0, AXIS_Y = 1} axis_e;
endpackage

// File: rtl/sq_overlap_stage.sv
// Stage 1: per-axis separation, push direction and overlap extent.
module sq_overlap_stage
  import sq_coll_pkg::*;
#(
  parameter int POS_W    = POS_W_D,
  parameter int POS_FRAC = POS_FRAC_D,
  parameter int SIDE_W   = SIDE_W_D,
  parameter int COEF_W   = COEF_W_D
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_valid,
  input  logic [N_AXES-1:0][POS_W-1:0]     a_pos,
  input  logic [N_AXES-1:0][POS_W-1:0]     b_pos,
  input  logic [SIDE_W-1:0]                a_side,
  input  logic [SIDE_W-1:0]                b_side,
  input  logic [COEF_W-1:0]                a_elas,
  input  logic [COEF_W-1:0]                b_elas,
  input  logic [COEF_W-1:0]                a_rmass,
  output logic                             s1_valid,
  output logic [N_AXES-1:0][POS_W-1:0]     s1_ovl,
  output logic [N_AXES-1:0][POS_W-1:0]     s1_dist,
  output logic [N_AXES-1:0]                s1_neg,
  output logic [COEF_W:0]                  s1_esum,
  output logic [COEF_W-1:0]                s1_rmass
);
  localparam int HS_W = POS_W + 1;

  logic [HS_W-1:0]              half_sum;
  logic [N_AXES-1:0][POS_W-1:0] dist_c;
  logic [N_AXES-1:0][POS_W-1:0] ovl_c;
  logic [N_AXES-1:0]            neg_c;

  // Side lengths are whole units; half of their sum in 8.8 is a shift by FRAC-1.
  assign half_sum = HS_W'({1'b0, a_side} + {1'b0, b_side}) << (POS_FRAC - 1);

  for (genvar k = 0; k < N_AXES; k++) begin : g_axis
    assign neg_c[k]  = a_pos[k] < b_pos[k];
    assign dist_c[k] = neg_c[k] ? (b_pos[k] - a_pos[k]) : (a_pos[k] - b_pos[k]);
    assign ovl_c[k]  = ({1'b0, dist_c[k]} < half_sum)
                       ? POS_W'(half_sum - {1'b0, dist_c[k]}) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_ovl   <= '0;
      s1_dist  <= '0;
      s1_neg   <= '0;
      s1_esum  <= '0;
      s1_rmass <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_ovl   <= ovl_c;
      s1_dist  <= dist_c;
      s1_neg   <= neg_c;
      s1_esum  <= {1'b0, a_elas} + {1'b0, b_elas};
      s1_rmass <= a_rmass;
    end
  end
endmodule

// File: rtl/sq_force_stage.sv
// Stages 2 and 3: overlap area and coefficient product, then area times separation.
module sq_force_stage
  import sq_coll_pkg::*;
#(
  parameter int POS_W  = POS_W_D,
  parameter int COEF_W = COEF_W_D
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               s1_valid,
  input  logic [N_AXES-1:0][POS_W-1:0]       s1_ovl,
  input  logic [N_AXES-1:0][POS_W-1:0]       s1_dist,
  input  logic [N_AXES-1:0]                  s1_neg,
  input  logic [COEF_W:0]                    s1_esum,
  input  logic [COEF_W-1:0]                  s1_rmass,
  output logic                               s3_valid,
  output logic [N_AXES-1:0][3*POS_W-1:0]     s3_px,
  output logic [2*COEF_W:0]                  s3_ed,
  output logic [N_AXES-1:0]                  s3_neg
);
  localparam int AREA_W = 2 * POS_W;
  localparam int PX_W   = 3 * POS_W;
  localparam int ED_W   = 2 * COEF_W + 1;

  logic                          s2_valid;
  logic [AREA_W-1:0]             s2_area;
  logic [N_AXES-1:0][POS_W-1:0]  s2_dist;
  logic [N_AXES-1:0]             s2_neg;
  logic [ED_W-1:0]               s2_ed;
  logic [N_AXES-1:0][PX_W-1:0]   px_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_area  <= '0;
      s2_dist  <= '0;
      s2_neg   <= '0;
      s2_ed    <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_area  <= AREA_W'(s1_ovl[AXIS_X]) * AREA_W'(s1_ovl[AXIS_Y]);
      s2_dist  <= s1_dist;
      s2_neg   <= s1_neg;
      s2_ed    <= ED_W'(s1_esum) * ED_W'(s1_rmass);
    end
  end

  for (genvar k = 0; k < N_AXES; k++) begin : g_px
    assign px_c[k] = PX_W'(s2_area) * PX_W'(s2_dist[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s3_valid <= 1'b0;
      s3_px    <= '0;
      s3_ed    <= '0;
      s3_neg   <= '0;
    end else begin
      s3_valid <= s2_valid;
      s3_px    <= px_c;
      s3_ed    <= s2_ed;
      s3_neg   <= s2_neg;
    end
  end
endmodule

// File: rtl/sq_accel_out.sv
// Stage 4: final product, rescale, sign, torque selection and clipping.
module sq_accel_out
  import sq_coll_pkg::*;
#(
  parameter int POS_W     = POS_W_D,
  parameter int POS_FRAC  = POS_FRAC_D,
  parameter int COEF_W    = COEF_W_D,
  parameter int COEF_FRAC = COEF_FRAC_D,
  parameter int ACC_W     = ACC_W_D
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               s3_valid,
  input  logic [N_AXES-1:0][3*POS_W-1:0]     s3_px,
  input  logic [2*COEF_W:0]                  s3_ed,
  input  logic [N_AXES-1:0]                  s3_neg,
  output logic                               out_valid,
  output logic signed [ACC_W-1:0]            acc_x,
  output logic signed [ACC_W-1:0]            acc_y,
  output logic signed [ACC_W-1:0]            acc_ang
);
  localparam int PROD_W = 3 * POS_W + 2 * COEF_W + 1;
  localparam int SHIFT  = 3 * POS_FRAC + 2 * COEF_FRAC;
  localparam int MAG_W  = PROD_W - SHIFT;
  localparam logic [MAG_W-1:0] POS_LIM = MAG_W'((64'd1 << (ACC_W - 1)) - 64'd1);
  localparam logic [MAG_W-1:0] NEG_LIM = POS_LIM + 1'b1;

  function automatic logic [ACC_W-1:0] clip(input logic [MAG_W-1:0] m, input logic neg);
    logic [ACC_W-1:0] low;
    low = m[ACC_W-1:0];
    if (neg) begin
      if (m >= NEG_LIM) return {1'b1, {(ACC_W-1){1'b0}}};
      return -low;
    end
    if (m > POS_LIM) return POS_LIM[ACC_W-1:0];
    return low;
  endfunction

  logic [N_AXES-1:0][PROD_W-1:0] prod;
  logic [N_AXES-1:0][MAG_W-1:0]  mag;
  logic [N_AXES-1:0][ACC_W-1:0]  lin;
  logic                          pick_y;
  logic [MAG_W-1:0]              pick_mag;
  logic                          pick_neg;

  for (genvar k = 0; k < N_AXES; k++) begin : g_lin
    assign prod[k] = PROD_W'(s3_px[k]) * PROD_W'(s3_ed);
    assign mag[k]  = MAG_W'(prod[k] >> SHIFT);
    assign lin[k]  = clip(mag[k], s3_neg[k]);
  end

  assign pick_y   = mag[AXIS_Y] > mag[AXIS_X];
  assign pick_mag = pick_y ? mag[AXIS_Y] : mag[AXIS_X];
  assign pick_neg = pick_y ? s3_neg[AXIS_Y] : s3_neg[AXIS_X];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      acc_x     <= '0;
      acc_y     <= '0;
      acc_ang   <= '0;
    end else begin
      out_valid <= s3_valid;
      acc_x     <= lin[AXIS_X];
      acc_y     <= lin[AXIS_Y];
      acc_ang   <= clip(pick_mag, ~pick_neg);
    end
  end
endmodule

// File: rtl/sq_collide_accel.sv
module sq_collide_accel
  import sq_coll_pkg::*;
#(
  parameter int POS_W     = POS_W_D,
  parameter int POS_FRAC  = POS_FRAC_D,
  parameter int SIDE_W    = SIDE_W_D,
  parameter int COEF_W    = COEF_W_D,
  parameter int COEF_FRAC = COEF_FRAC_D,
  parameter int ACC_W     = ACC_W_D
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [POS_W-1:0]        a_x,
  input  logic [POS_W-1:0]        a_y,
  input  logic [SIDE_W-1:0]       a_side,
  input  logic [COEF_W-1:0]       a_elas,
  input  logic [COEF_W-1:0]       a_rmass,
  input  logic [POS_W-1:0]        b_x,
  input  logic [POS_W-1:0]        b_y,
  input  logic [SIDE_W-1:0]       b_side,
  input  logic [COEF_W-1:0]       b_elas,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] acc_x,
  output logic signed [ACC_W-1:0] acc_y,
  output logic signed [ACC_W-1:0] acc_ang
);
  logic [N_AXES-1:0][POS_W-1:0]   a_pos, b_pos;
  logic                           s1_valid, s3_valid;
  logic [N_AXES-1:0][POS_W-1:0]   s1_ovl, s1_dist;
  logic [N_AXES-1:0]              s1_neg, s3_neg;
  logic [COEF_W:0]                s1_esum;
  logic [COEF_W-1:0]              s1_rmass;
  logic [N_AXES-1:0][3*POS_W-1:0] s3_px;
  logic [2*COEF_W:0]              s3_ed;

  assign a_pos[AXIS_X] = a_x;
  assign a_pos[AXIS_Y] = a_y;
  assign b_pos[AXIS_X] = b_x;
  assign b_pos[AXIS_Y] = b_y;

  sq_overlap_stage #(
    .POS_W(POS_W), .POS_FRAC(POS_FRAC), .SIDE_W(SIDE_W), .COEF_W(COEF_W)
  ) i_overlap (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_pos(a_pos), .b_pos(b_pos), .a_side(a_side), .b_side(b_side),
    .a_elas(a_elas), .b_elas(b_elas), .a_rmass(a_rmass),
    .s1_valid(s1_valid), .s1_ovl(s1_ovl), .s1_dist(s1_dist), .s1_neg(s1_neg),
    .s1_esum(s1_esum), .s1_rmass(s1_rmass)
  );

  sq_force_stage #(
    .POS_W(POS_W), .COEF_W(COEF_W)
  ) i_force (
    .clk(clk), .rst(rst),
    .s1_valid(s1_valid), .s1_ovl(s1_ovl), .s1_dist(s1_dist), .s1_neg(s1_neg),
    .s1_esum(s1_esum), .s1_rmass(s1_rmass),
    .s3_valid(s3_valid), .s3_px(s3_px), .s3_ed(s3_ed), .s3_neg(s3_neg)
  );

  sq_accel_out #(
    .POS_W(POS_W), .POS_FRAC(POS_FRAC), .COEF_W(COEF_W),
    .COEF_FRAC(COEF_FRAC), .ACC_W(ACC_W)
  ) i_out (
    .clk(clk), .rst(rst),
    .s3_valid(s3_valid), .s3_px(s3_px), .s3_ed(s3_ed), .s3_neg(s3_neg),
    .out_valid(out_valid), .acc_x(acc_x), .acc_y(acc_y), .acc_ang(acc_ang)
  );
endmodule

// File: rtl/sq_collide_accel_chk.sv
module sq_collide_accel_chk #(
  parameter int POS_W    = 16,
  parameter int POS_FRAC = 8,
  parameter int SIDE_W   = 5,
  parameter int ACC_W    = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [POS_W-1:0]        a_x,
  input logic [POS_W-1:0]        a_y,
  input logic [SIDE_W-1:0]       a_side,
  input logic [POS_W-1:0]        b_x,
  input logic [POS_W-1:0]        b_y,
  input logic [SIDE_W-1:0]       b_side,
  input logic                    out_valid,
  input logic signed [ACC_W-1:0] acc_x,
  input logic signed [ACC_W-1:0] acc_y,
  input logic signed [ACC_W-1:0] acc_ang
);
  logic [2:0]       since_rst;
  logic [POS_W:0]   hs, sep_x, sep_y;
  logic             apart;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst < 3'd4) since_rst <= since_rst + 3'd1;
  end

  assign hs    = (POS_W+1)'({1'b0, a_side} + {1'b0, b_side}) << (POS_FRAC - 1);
  assign sep_x = (a_x > b_x) ? {1'b0, a_x - b_x} : {1'b0, b_x - a_x};
  assign sep_y = (a_y > b_y) ? {1'b0, a_y - b_y} : {1'b0, b_y - a_y};
  assign apart = (sep_x >= hs) || (sep_y >= hs);

  // R7: valid emerges four edges after it is sampled
  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R1: separated or touching squares give all-zero results
  a_r1_no_contact: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd4 && out_valid && $past(apart, 4))
      |-> (acc_x == 0 && acc_y == 0 && acc_ang == 0));

  // R4: push direction on x follows the centre ordering
  a_r4_sign_neg: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd4 && out_valid && $past(a_x < b_x, 4)) |-> (acc_x <= 0));
  a_r4_sign_pos: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd4 && out_valid && $past(a_x >= b_x, 4)) |-> (acc_x >= 0));

  // R5: torque is zero exactly when both linear terms are zero
  a_r5_ang_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((acc_ang == 0) == (acc_x == 0 && acc_y == 0)));

  // R8: reset clears the result port
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && acc_x == 0 && acc_y == 0 && acc_ang == 0));
endmodule

bind sq_collide_accel sq_collide_accel_chk #(
  .POS_W(POS_W), .POS_FRAC(POS_FRAC), .SIDE_W(SIDE_W), .ACC_W(ACC_W)
) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .a_x(a_x), .a_y(a_y), .a_side(a_side), .b_x(b_x), .b_y(b_y), .b_side(b_side),
  .out_valid(out_valid), .acc_x(acc_x), .acc_y(acc_y), .acc_ang(acc_ang)
);

// File: tb/test_sq_collide_accel.sv
module test_sq_collide_accel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] a_x = '0, a_y = '0, b_x = '0, b_y = '0;
  logic [4:0]  a_side = '0, b_side = '0;
  logic [7:0]  a_elas = '0, b_elas = '0, a_rmass = '0;
  logic        out_valid;
  logic signed [15:0] acc_x, acc_y, acc_ang;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  typedef struct {
    int ax, ay, bx, by, sa, sb, ea, eb, rm, v;
  } stim_t;
  stim_t stim[8];

  always #2 clk = ~clk;

  sq_collide_accel i_sq_collide_accel (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_x(a_x), .a_y(a_y), .a_side(a_side), .a_elas(a_elas), .a_rmass(a_rmass),
    .b_x(b_x), .b_y(b_y), .b_side(b_side), .b_elas(b_elas),
    .out_valid(out_valid), .acc_x(acc_x), .acc_y(acc_y), .acc_ang(acc_ang)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clamp(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // Reference model from R1..R6, all in 64-bit integers.
  function automatic void model(input stim_t s, output int ex, output int ey, output int ea);
    longint hs, dx, dy, ovx, ovy, k, mx, my, vx, vy, vp;
    hs  = longint'(s.sa + s.sb) * 128;
    dx  = (s.ax > s.bx) ? s.ax - s.bx : s.bx - s.ax;
    dy  = (s.ay > s.by) ? s.ay - s.by : s.by - s.ay;
    ovx = (dx < hs) ? hs - dx : 0;
    ovy = (dy < hs) ? hs - dy : 0;
    k   = longint'(s.ea + s.eb) * s.rm;
    mx  = (ovx * ovy * dx * k) >>> 32;
    my  = (ovx * ovy * dy * k) >>> 32;
    vx  = (s.ax < s.bx) ? -mx : mx;
    vy  = (s.ay < s.by) ? -my : my;
    vp  = (my > mx) ? vy : vx;
    ex  = clamp(vx);
    ey  = clamp(vy);
    ea  = clamp(-vp);
  endfunction

  task automatic set_vec(input int i, input int ax, input int ay, input int bx, input int by,
                         input int sa, input int sb, input int ea, input int eb,
                         input int rm, input int v);
    stim[i] = '{ax:ax, ay:ay, bx:bx, by:by, sa:sa, sb:sb, ea:ea, eb:eb, rm:rm, v:v};
  endtask

  task automatic drive(input stim_t s);
    in_valid = s.v[0];
    a_x = 16'(s.ax); a_y = 16'(s.ay); b_x = 16'(s.bx); b_y = 16'(s.by);
    a_side = 5'(s.sa); b_side = 5'(s.sb);
    a_elas = 8'(s.ea); b_elas = 8'(s.eb); a_rmass = 8'(s.rm);
  endtask

  task automatic idle();
    in_valid = 1'b0;
  endtask

  // Drives n vectors on consecutive falling edges; results are due four
  // falling edges after each drive (R7).
  task automatic run_batch(input int n, input string tag);
    int ex, ey, ea;
    for (int c = 0; c < n + 4; c++) begin
      @(negedge clk);
      if (c >= 4) begin
        chk({tag, " R7 valid"}, int'(out_valid), stim[c-4].v);
        if (stim[c-4].v != 0) begin
          model(stim[c-4], ex, ey, ea);
          chk({tag, " acc_x"}, int'(acc_x), ex);
          chk({tag, " acc_y"}, int'(acc_y), ey);
          chk({tag, " acc_ang"}, int'(acc_ang), ea);
        end
      end else begin
        chk({tag, " R7 idle"}, int'(out_valid), 0);
      end
      if (c < n) drive(stim[c]); else idle();
    end
  endtask

  // R8: state held in reset
  task automatic t_reset_state();
    @(negedge clk);
    chk("R8 reset valid", int'(out_valid), 0);
    chk("R8 reset acc_x", int'(acc_x), 0);
    chk("R8 reset acc_ang", int'(acc_ang), 0);
  endtask

  // R2 R3 R4 R5: basic overlap, A below-left of B (x -1440, y -576, ang +1440)
  task automatic t_basic();
    set_vec(0, 100*256, 100*256, 110*256, 104*256, 16, 16, 16, 16, 16, 1);
    set_vec(1, 50*256+128, 60*256+64, 48*256, 57*256, 12, 8, 8, 4, 24, 1);
    run_batch(2, "R2/R3 basic");
  endtask

  // R1: separated on one axis, and exactly touching
  task automatic t_no_contact();
    set_vec(0, 100*256, 100*256, 120*256, 101*256, 16, 16, 16, 16, 16, 1);
    set_vec(1, 100*256, 100*256, 116*256, 101*256, 16, 16, 16, 16, 16, 1);
    set_vec(2, 100*256, 100*256, 101*256, 84*256, 16, 16, 16, 16, 16, 1);
    run_batch(3, "R1 no contact");
  endtask

  // R4 R5: A above-right of B, and an equal-magnitude tie with mixed signs
  task automatic t_signs();
    set_vec(0, 110*256, 104*256, 100*256, 100*256, 16, 16, 16, 16, 16, 1);
    set_vec(1, 100*256, 106*256, 106*256, 100*256, 16, 16, 16, 16, 16, 1);
    set_vec(2, 100*256, 100*256, 100*256, 103*256, 10, 10, 16, 16, 16, 1);
    run_batch(3, "R4/R5 signs");
  endtask

  // R6: clipping at both ends, angular term on the opposite end
  task automatic t_saturate();
    set_vec(0, 100*256, 50*256, 90*256, 50*256, 31, 31, 255, 255, 255, 1);
    set_vec(1, 90*256, 50*256, 100*256, 50*256, 31, 31, 255, 255, 255, 1);
    run_batch(2, "R6 clip");
  endtask

  // R7: back-to-back stream with a bubble
  task automatic t_stream();
    set_vec(0, 100*256, 100*256, 108*256, 103*256, 20, 12, 20, 12, 30, 1);
    set_vec(1, 30*256, 30*256, 27*256, 35*256, 8, 8, 16, 16, 16, 1);
    set_vec(2, 200*256, 20*256, 195*256, 20*256+200, 6, 14, 3, 9, 40, 1);
    set_vec(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    set_vec(4, 70*256, 70*256, 71*256, 69*256, 4, 4, 16, 16, 16, 1);
    set_vec(5, 10*256, 10*256, 10*256, 10*256, 8, 8, 16, 16, 16, 1);
    run_batch(6, "R7 stream");
  endtask

  // R8: reset while pairs are in flight discards them
  task automatic t_reset_mid();
    set_vec(0, 100*256, 100*256, 110*256, 104*256, 16, 16, 16, 16, 16, 1);
    @(negedge clk); drive(stim[0]);
    @(negedge clk); drive(stim[0]);
    @(negedge clk); idle(); rst = 1'b1;
    @(negedge clk);
    chk("R8 mid valid", int'(out_valid), 0);
    chk("R8 mid acc_x", int'(acc_x), 0);
    rst = 1'b0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R8 flushed", int'(out_valid), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    t_basic();
    t_no_contact();
    t_signs();
    t_saturate();
    t_stream();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule